// File: doc/BRIEF.md
# ASID-Tagged Translation Buffer with Selective Flush

This block is a small direct-mapped translation lookaside buffer for a 32-bit core with 4 KiB pages. Each line holds a virtual tag, a page frame number, a 5-bit address-space tag and a global flag. The current address space comes from a 5-bit field of the processor status word. Mappings from several processes can therefore stay resident across context switches, and kernel mappings marked global match in every address space.

Software installs a line by presenting two staging words in one cycle. The virtual word carries the page number and, in its spare low bits, the address-space tag. The physical word carries the frame number and the global flag. Two maintenance walks visit one line per cycle and raise a busy output while they run. Flush-all writes every line invalid and never looks at the contents. Flush-by-tag reads each line and clears it only when the stored tag matches the requested one and the line is not global.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, `hit_o` is 0, `pa_o` is 0 and `busy_o` is 0.
- R2: A lookup presented with `lookup_valid_i` high gives its result on `hit_o`/`pa_o` in the next cycle. It hits only when the line at index `lookup_va_i[16:12]` is valid, its tag equals `lookup_va_i[31:17]`, and its stored tag equals the current address space `status_word_i[16:12]` (or the line is global). Other status word bits have no effect.
- R3: A global line hits for every value of the current address space.
- R4: On a hit `pa_o` is the stored frame number followed by `lookup_va_i[11:0]`. On a miss `pa_o` is 0.
- R5: A cycle with `upd_we_i` high writes a valid line at index `upd_va_i[16:12]`. The line takes its tag from `upd_va_i[31:17]`, its address-space tag from `upd_va_i[4:0]`, its frame from `upd_pa_i[31:12]` and its global flag from `upd_pa_i[0]`.
- R6: When a lookup and an update reach the same index in the same cycle, the lookup returns the line as it was before the update.
- R7: A flush-all request while idle raises `busy_o` from the next cycle for exactly 32 cycles. Afterwards every lookup misses.
- R8: A flush-by-tag request (`flush_asid_i`, tag on `flush_asid_val_i`) keeps `busy_o` high for 32 cycles. It invalidates exactly the valid, non-global lines whose stored tag equals the request. All other lines still hit afterwards. If both requests come in the same cycle, flush-all wins.
- R9: While `busy_o` is high, lookups miss, updates are ignored and new flush requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_word_i | input | 32 | Processor status word; bits [16:12] are the current address space |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_va_i | input | 32 | Virtual address to translate |
| hit_o | output | 1 | Registered lookup hit |
| pa_o | output | 32 | Registered physical address, 0 on miss |
| upd_we_i | input | 1 | Write one line from the staging words |
| upd_va_i | input | 32 | Virtual staging word: page number, address-space tag in [4:0] |
| upd_pa_i | input | 32 | Physical staging word: frame number, global flag in [0] |
| flush_all_i | input | 1 | Start a flush of every line |
| flush_asid_i | input | 1 | Start a flush of one address space |
| flush_asid_val_i | input | 5 | Address space to flush |
| busy_o | output | 1 | A flush walk is in progress |

## Verification
The bound checker watches several things on every cycle. It confirms that a flush request while idle raises busy, that every busy period lasts exactly one line per entry, that no hit appears in the cycle after a busy lookup, that a miss drives a zero address, and that a hit keeps the page offset of the lookup before it. Which lines hit for which address space, the old-contents rule on a same-index collision, the survival of global lines and other address spaces through a selective flush, and the dropping of updates during a walk all depend on stored contents. Only the bench's sweeps can show these, by comparing every lookup against a model of the line array.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_W  = 12;
  localparam int ASID_W  = 5;
  localparam int IDX_W   = 5;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = VA_W - PAGE_W - IDX_W;
  localparam int PFN_W   = VA_W - PAGE_W;

  typedef struct packed {
    logic              valid;
    logic              glb;
    logic [ASID_W-1:0] asid;
    logic [TAG_W-1:0]  tag;
    logic [PFN_W-1:0]  pfn;
  } tlb_line_t;
endpackage

// File: rtl/asid_tlb_store.sv
module asid_tlb_store
  import asid_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_line_t        wr_line_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output tlb_line_t        rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output tlb_line_t        rd_b_o
);
  tlb_line_t lines [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    tlb_line_t line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q <= '0;
      end else if (clr_en_i && clr_idx_i == IDX_W'(g)) begin
        line_q.valid <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        line_q <= wr_line_i;
      end
    end
    assign lines[g] = line_q;
  end

  assign rd_a_o = lines[rd_a_idx_i];
  assign rd_b_o = lines[rd_b_idx_i];
endmodule

// File: rtl/asid_tlb_flush.sv
module asid_tlb_flush
  import asid_tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] asid_i,
  input  tlb_line_t         line_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              clr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic              busy_q, by_asid_q;
  logic [ASID_W-1:0] tgt_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              sel_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      by_asid_q <= 1'b0;
      tgt_q     <= '0;
      cnt_q     <= '0;
    end else if (!busy_q) begin
      if (flush_all_i || flush_asid_i) begin
        busy_q    <= 1'b1;
        by_asid_q <= !flush_all_i;  // flush-all wins
        tgt_q     <= asid_i;
        cnt_q     <= '0;
      end
    end else begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // selective walk reads the line; flush-all never looks at it
  assign sel_match = line_i.valid && !line_i.glb && (line_i.asid == tgt_q);
  assign clr_o     = busy_q && (!by_asid_q || sel_match);
  assign idx_o     = cnt_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/asid_tlb_match.sv
module asid_tlb_match
  import asid_tlb_pkg::*;
(
  input  tlb_line_t         line_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic [VA_W-1:0]   pa_o
);
  logic [TAG_W-1:0] va_tag;

  assign va_tag = va_i[VA_W-1 -: TAG_W];
  assign hit_o  = line_i.valid && (line_i.tag == va_tag) &&
                  (line_i.glb || line_i.asid == asid_i);
  assign pa_o   = hit_o ? {line_i.pfn, va_i[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ASID_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   status_word_i,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_va_i,
  output logic              hit_o,
  output logic [VA_W-1:0]   pa_o,
  input  logic              upd_we_i,
  input  logic [VA_W-1:0]   upd_va_i,
  input  logic [VA_W-1:0]   upd_pa_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i,
  output logic              busy_o
);
  logic [ASID_W-1:0] cur_asid;
  tlb_line_t         wr_line, look_line, walk_line;
  logic [IDX_W-1:0]  look_idx, wr_idx, walk_idx;
  logic              walk_clr, busy, wr_en;
  logic              m_hit;
  logic [VA_W-1:0]   m_pa;
  logic              hit_q;
  logic [VA_W-1:0]   pa_q;
  logic              unused_bits;

  assign cur_asid = status_word_i[ASID_LSB +: ASID_W];
  assign look_idx = lookup_va_i[PAGE_W +: IDX_W];
  assign wr_idx   = upd_va_i[PAGE_W +: IDX_W];
  assign wr_en    = upd_we_i && !busy;

  always_comb begin
    wr_line       = '0;
    wr_line.valid = 1'b1;
    wr_line.glb   = upd_pa_i[0];
    wr_line.asid  = upd_va_i[ASID_W-1:0];
    wr_line.tag   = upd_va_i[VA_W-1 -: TAG_W];
    wr_line.pfn   = upd_pa_i[VA_W-1 -: PFN_W];
  end

  asid_tlb_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_line_i  (wr_line),
    .clr_en_i   (walk_clr),
    .clr_idx_i  (walk_idx),
    .rd_a_idx_i (look_idx),
    .rd_a_o     (look_line),
    .rd_b_idx_i (walk_idx),
    .rd_b_o     (walk_line)
  );

  asid_tlb_flush u_flush (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_all_i  (flush_all_i),
    .flush_asid_i (flush_asid_i),
    .asid_i       (flush_asid_val_i),
    .line_i       (walk_line),
    .busy_o       (busy),
    .idx_o        (walk_idx),
    .clr_o        (walk_clr)
  );

  asid_tlb_match u_match (
    .line_i (look_line),
    .va_i   (lookup_va_i),
    .asid_i (cur_asid),
    .hit_o  (m_hit),
    .pa_o   (m_pa)
  );

  // array read happens before the same-edge write lands: old contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      pa_q  <= '0;
    end else begin
      hit_q <= lookup_valid_i && !busy && m_hit;
      pa_q  <= (lookup_valid_i && !busy) ? m_pa : '0;
    end
  end

  assign hit_o  = hit_q;
  assign pa_o   = pa_q;
  assign busy_o = busy;

  assign unused_bits = ^{status_word_i, upd_va_i[PAGE_W-1:ASID_W], upd_pa_i[PAGE_W-1:1]};
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker
  import asid_tlb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lookup_valid_i,
  input logic [VA_W-1:0] lookup_va_i,
  input logic            flush_all_i,
  input logic            flush_asid_i,
  input logic            hit_o,
  input logic [VA_W-1:0] pa_o,
  input logic            busy_o
);
  logic [IDX_W:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= '0;
    else if (!busy_o) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  a_r7_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (flush_all_i || flush_asid_i)) |=> busy_o);

  a_r8_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_cnt == (IDX_W+1)'(ENTRIES)));

  a_r9_busy_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !hit_o);

  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0));

  a_r4_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[PAGE_W-1:0] == $past(lookup_va_i[PAGE_W-1:0])));

  a_r2_hit_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lookup_valid_i));
endmodule

bind asid_tlb asid_tlb_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_va_i    (lookup_va_i),
  .flush_all_i    (flush_all_i),
  .flush_asid_i   (flush_asid_i),
  .hit_o          (hit_o),
  .pa_o           (pa_o),
  .busy_o         (busy_o)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] status_word_i = '0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_va_i = '0;
  logic        hit_o;
  logic [31:0] pa_o;
  logic        upd_we_i = 1'b0;
  logic [31:0] upd_va_i = '0;
  logic [31:0] upd_pa_i = '0;
  logic        flush_all_i = 1'b0;
  logic        flush_asid_i = 1'b0;
  logic [4:0]  flush_asid_val_i = '0;
  logic        busy_o;

  int checks = 0;
  int fails  = 0;

  logic        m_valid [N];
  logic        m_glb   [N];
  logic [4:0]  m_asid  [N];
  logic [14:0] m_tag   [N];
  logic [19:0] m_pfn   [N];

  asid_tlb uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] status_for(input logic [4:0] a);
    return (32'hA5A5_0F0F & ~(32'h1F << 12)) | (32'(a) << 12);
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va, input logic [4:0] a);
    int idx = int'(va[16:12]);
    if (m_valid[idx] && m_tag[idx] == va[31:17] && (m_glb[idx] || m_asid[idx] == a))
      return {m_pfn[idx], va[11:0]};
    return '0;
  endfunction

  task automatic look(input logic [31:0] va, input logic [4:0] a, input string req);
    logic [31:0] e;
    @(negedge clk_i);
    e = exp_pa(va, a);
    lookup_valid_i = 1'b1;
    lookup_va_i    = va;
    status_word_i  = status_for(a);
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    check(hit_o == (e != 0), req, "hit", 32'(hit_o), 32'(e != 0));
    check(pa_o == e, req, "pa", pa_o, e);
  endtask

  function automatic logic [31:0] va_of(input int i, input logic [11:0] low);
    return {15'(i * 37 + 5), 5'(i), low};
  endfunction

  task automatic model_write(input logic [31:0] va, input logic [31:0] pa);
    int idx = int'(va[16:12]);
    m_valid[idx] = 1'b1;
    m_glb[idx]   = pa[0];
    m_asid[idx]  = va[4:0];
    m_tag[idx]   = va[31:17];
    m_pfn[idx]   = pa[31:12];
  endtask

  task automatic update(input logic [31:0] va, input logic [31:0] pa);
    @(negedge clk_i);
    upd_we_i = 1'b1; upd_va_i = va; upd_pa_i = pa;
    @(negedge clk_i);
    upd_we_i = 1'b0;
    model_write(va, pa);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++)
      for (int a = 0; a < 5; a++)
        look(va_of(i, 12'(i * 97 + a)), 5'(a), (req != "") ? req : (m_glb[i] ? "R3" : "R2"));
  endtask

  // flush with probes: lookup, update and a second request while busy
  task automatic flush(input bit all, input logic [4:0] t, input bit probe);
    int n;
    logic [31:0] pva;
    @(negedge clk_i);
    flush_all_i = all; flush_asid_i = !all; flush_asid_val_i = t;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_asid_i = 1'b0;
    check(busy_o == 1'b1, all ? "R7" : "R8", "busy rise", 32'(busy_o), 1);
    n = 1;
    if (probe) begin
      lookup_valid_i = 1'b1; lookup_va_i = va_of(0, 12'h123);
      status_word_i  = status_for(5'd1);
      upd_we_i = 1'b1; upd_va_i = {15'h7ABC, 5'd2, 12'h003}; upd_pa_i = 32'hFFFF_F000;
      flush_all_i = 1'b1;
      @(negedge clk_i);
      lookup_valid_i = 1'b0; upd_we_i = 1'b0; flush_all_i = 1'b0;
      check(hit_o == 1'b0, "R9", "lookup while busy", 32'(hit_o), 0);
      n++;
    end
    forever begin
      @(negedge clk_i);
      if (!busy_o) break;
      n++;
    end
    check(n == N, all ? "R7" : "R8", "busy length", n, N);
    @(negedge clk_i);
    check(busy_o == 1'b0, "R9", "no restart", 32'(busy_o), 0);
    for (int i = 0; i < N; i++)
      if (all || (m_valid[i] && !m_glb[i] && m_asid[i] == t)) m_valid[i] = 1'b0;
    if (probe) begin
      pva = {15'h7ABC, 5'd2, 12'h003};
      look(pva, 5'd2, "R9");
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_glb[i] = 0; m_asid[i] = 0; m_tag[i] = 0; m_pfn[i] = 0;
    end
    repeat (3) @(posedge clk_i);
    check(hit_o == 0 && pa_o == 0, "R1", "reset outputs", pa_o, 0);
    check(busy_o == 0, "R1", "reset busy", 32'(busy_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) look(va_of(i, 12'h0), 5'd1, "R1");

    // R5: fill every line
    for (int i = 0; i < N; i++)
      update({va_of(i, 12'h0)[31:12], 7'h0, 5'(i % 4 + 1)},
             {20'(i * 1111 + 3), 11'h0, 1'(i % 8 == 0)});
    sweep("");
    for (int i = 0; i < N; i += 3)
      look(va_of(i, 12'hABC) ^ 32'h0002_0000, m_asid[i], "R2");

    // R6: same-index update and lookup in one cycle
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_va_i = va_of(3, 12'h456);
    status_word_i  = status_for(m_asid[3]);
    upd_we_i = 1'b1; upd_va_i = {15'h1357, 5'd3, 7'h0, m_asid[3]};
    upd_pa_i = {20'hBEEF1, 12'h0};
    @(negedge clk_i);
    lookup_valid_i = 1'b0; upd_we_i = 1'b0;
    check(hit_o == 1'b1, "R6", "old hit", 32'(hit_o), 1);
    check(pa_o == {m_pfn[3], 12'h456}, "R6", "old pa", pa_o, {m_pfn[3], 12'h456});
    model_write({15'h1357, 5'd3, 7'h0, m_asid[3]}, {20'hBEEF1, 12'h0});
    look({15'h1357, 5'd3, 12'h789}, m_asid[3], "R6");
    look(va_of(3, 12'h789), m_asid[3], "R6");

    // R8: selective flush of address space 1, with R9 probes
    flush(1'b0, 5'd1, 1'b1);
    sweep("R8");

    // R8: flush-all wins when both requests arrive together
    @(negedge clk_i);
    flush_all_i = 1'b1; flush_asid_i = 1'b1; flush_asid_val_i = 5'd9;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_asid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    sweep("R7");

    summary();
    $finish;
  end
endmodule